// File: doc/BRIEF.md
# ATM Cell Steering Classifier

This block decides where each incoming ATM cell goes once its connection has been looked up. A cell arrives with its first four header octets, a flag saying whether the connection lookup found the virtual channel, and that channel's two steering flags. Two global configuration inputs cover cells whose connection is unknown. From the payload type field the block works out whether the cell is an operations and maintenance (OAM) cell. It then sends the cell to the CPU data cell FIFO, to the reassembly path, or drops it.

The decision is captured in an output register and held there until downstream takes it. Input and output use a valid/ready handshake. Unknown cells that go to the CPU carry a shared slot code: one for all unknown user cells and one for all unknown OAM cells. A downstream FIFO writer uses that code to place them in their common destination. Dropped cells produce no output. Each one increments a saturating drop counter.

Top module: `cell_steer_top`

## Requirements
- R1: The payload type field is bits [3:1] of the fourth header octet, which sits at `in_hdr[7:0]` in the default layout. A cell is OAM when bit 3 of that octet is set. The output carries the cell's payload type as `out_pti`.
- R2: A known OAM cell goes to the CPU (`out_dest`=1) when `in_vc_oam_cpu` is 1. Otherwise it goes to reassembly (`out_dest`=0). The global flags have no effect on it, and `out_slot` is 0.
- R3: A known non-OAM cell goes to the CPU when `in_vc_user_cpu` is 1 and to reassembly otherwise, with `out_slot`=0. The global flags have no effect on it.
- R4: An unknown non-OAM cell goes to the CPU with `out_slot`=1 when `cfg_unk_user_cpu` is 1. The per-channel flags have no effect on it.
- R5: An unknown OAM cell goes to the CPU with `out_slot`=2 when `cfg_unk_oam_cpu` is 1. The per-channel flags have no effect on it.
- R6: An unknown cell whose global flag is 0 produces no output. `drop_count` rises by one in the cycle after it is accepted and saturates at its maximum. At no other time does `drop_count` change.
- R7: While `out_valid` is 1 and `out_ready` is 0, every output field holds its value.
- R8: `in_ready` is 1 exactly when the output register is empty or is being emptied this cycle. A cell accepted in one cycle shows its decision on the outputs after the next clock edge.
- R9: During reset `out_valid` and `drop_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A cell is presented |
| in_ready | output | 1 | The block can take a cell this cycle |
| in_hdr | input | HDR_W | First four header octets, octet 1 in the top byte by default |
| in_tag | input | TAG_W | Cell handle passed through to the output |
| in_known | input | 1 | The connection lookup found the channel |
| in_vc_oam_cpu | input | 1 | Per-channel flag: send OAM cells to the CPU |
| in_vc_user_cpu | input | 1 | Per-channel flag: send non-OAM cells to the CPU |
| cfg_unk_user_cpu | input | 1 | Global flag: send unknown non-OAM cells to the CPU |
| cfg_unk_oam_cpu | input | 1 | Global flag: send unknown OAM cells to the CPU |
| out_valid | output | 1 | A decision is held |
| out_ready | input | 1 | Downstream takes the decision |
| out_dest | output | 1 | 0 = reassembly, 1 = CPU data cell FIFO |
| out_slot | output | 2 | 0 = per-channel, 1 = shared unknown-user slot, 2 = shared unknown-OAM slot |
| out_pti | output | 3 | Payload type of the cell |
| out_tag | output | TAG_W | Handle of the cell |
| drop_count | output | CNT_W | Saturating count of dropped cells |

## Verification
The assertions check on every cycle the following properties. Each accepted cell gets the destination and slot its flags call for, and the payload type appears one cycle after acceptance. Dropped cells leave the output empty. The counter moves only on a drop. Outputs stay frozen under backpressure, and `in_ready` falls while the output is blocked. Only the bench's scenarios can show that the counter saturates instead of wrapping. They also show that long mixed streams with random backpressure lose, duplicate or reorder no cell handle, and that the ignored flags stay ignored when they are toggled against each case.

// File: rtl/cell_steer_pkg.sv
package cell_steer_pkg;
   typedef enum logic [0:0] {
      DEST_REASM = 1'b0,
      DEST_CPU   = 1'b1
   } dest_e;

   typedef enum logic [1:0] {
      SLOT_VC       = 2'd0,
      SLOT_UNK_USER = 2'd1,
      SLOT_UNK_OAM  = 2'd2
   } slot_e;

   typedef struct packed {
      logic  keep;
      dest_e dest;
      slot_e slot;
   } verdict_t;

   localparam int PTI_W = 3;
endpackage

// File: rtl/cell_hdr_decode.sv
module cell_hdr_decode
   import cell_steer_pkg::*;
#(
   parameter int HDR_W         = 32,
   parameter bit OCTET4_AT_LSB = 1'b1
) (
   input  logic [HDR_W-1:0] hdr,
   output logic [PTI_W-1:0] pti,
   output logic             is_oam
);
   localparam int OCT_LO = OCTET4_AT_LSB ? 0 : HDR_W - 8;

   generate
      if (HDR_W < 32) begin : g_bad_width
         $error("cell_hdr_decode: HDR_W must hold four octets");
      end
   endgenerate

   logic [7:0] octet4;

   generate
      if (OCTET4_AT_LSB) begin : g_lsb
         assign octet4 = hdr[7:0];
      end else begin : g_msb
         assign octet4 = hdr[HDR_W-1 -: 8];
      end
   endgenerate

   assign pti    = octet4[3:1];
   assign is_oam = pti[PTI_W-1];

   logic unused_hdr;
   assign unused_hdr = ^{hdr, octet4[7:4], octet4[0], OCT_LO[0]};
endmodule

// File: rtl/cell_steer_policy.sv
module cell_steer_policy
   import cell_steer_pkg::*;
(
   input  logic     is_oam,
   input  logic     known,
   input  logic     vc_oam_cpu,
   input  logic     vc_user_cpu,
   input  logic     unk_user_cpu,
   input  logic     unk_oam_cpu,
   output verdict_t verdict
);
   always_comb begin
      verdict = '{keep: 1'b1, dest: DEST_REASM, slot: SLOT_VC};
      if (known) begin
         if (is_oam ? vc_oam_cpu : vc_user_cpu) verdict.dest = DEST_CPU;
      end else if (is_oam) begin
         verdict.keep = unk_oam_cpu;
         verdict.dest = DEST_CPU;
         verdict.slot = SLOT_UNK_OAM;
      end else begin
         verdict.keep = unk_user_cpu;
         verdict.dest = DEST_CPU;
         verdict.slot = SLOT_UNK_USER;
      end
   end
endmodule

// File: rtl/cell_steer_outreg.sv
module cell_steer_outreg
   import cell_steer_pkg::*;
#(
   parameter int TAG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  verdict_t         verdict,
   input  logic [PTI_W-1:0] pti,
   input  logic [TAG_W-1:0] tag,
   output logic             drop_pulse,
   output logic             out_valid,
   input  logic             out_ready,
   output logic             out_dest,
   output logic [1:0]       out_slot,
   output logic [PTI_W-1:0] out_pti,
   output logic [TAG_W-1:0] out_tag
);
   generate
      if (TAG_W < 1) begin : g_bad_tag
         $error("cell_steer_outreg: TAG_W must be at least 1");
      end
   endgenerate

   logic accept;
   logic load;

   assign in_ready   = !out_valid || out_ready;
   assign accept     = in_valid && in_ready;
   assign load       = accept && verdict.keep;
   assign drop_pulse = accept && !verdict.keep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_dest  <= 1'b0;
         out_slot  <= '0;
         out_pti   <= '0;
         out_tag   <= '0;
      end else if (in_ready) begin
         out_valid <= load;
         if (load) begin
            out_dest <= verdict.dest;
            out_slot <= verdict.slot;
            out_pti  <= pti;
            out_tag  <= tag;
         end
      end
   end
endmodule

// File: rtl/cell_drop_counter.sv
module cell_drop_counter #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bump,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (CNT_W < 1 || CNT_W > 48) begin : g_bad_cnt
         $error("cell_drop_counter: CNT_W out of range");
      end
   endgenerate

   logic [CNT_W-1:0] next;

   generate
      if (SATURATE) begin : g_sat
         assign next = (count == CNT_MAX) ? count : count + 1'b1;
      end else begin : g_wrap
         assign next = count + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (bump) count <= next;
   end
endmodule

// File: rtl/cell_steer_top.sv
module cell_steer_top
   import cell_steer_pkg::*;
#(
   parameter int HDR_W         = 32,
   parameter bit OCTET4_AT_LSB = 1'b1,
   parameter int TAG_W         = 8,
   parameter int CNT_W         = 16,
   parameter bit CNT_SATURATE  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [HDR_W-1:0] in_hdr,
   input  logic [TAG_W-1:0] in_tag,
   input  logic             in_known,
   input  logic             in_vc_oam_cpu,
   input  logic             in_vc_user_cpu,
   input  logic             cfg_unk_user_cpu,
   input  logic             cfg_unk_oam_cpu,
   output logic             out_valid,
   input  logic             out_ready,
   output logic             out_dest,
   output logic [1:0]       out_slot,
   output logic [2:0]       out_pti,
   output logic [TAG_W-1:0] out_tag,
   output logic [CNT_W-1:0] drop_count
);
   logic [PTI_W-1:0] pti;
   logic             is_oam;
   verdict_t         verdict;
   logic             drop_pulse;

   cell_hdr_decode #(.HDR_W(HDR_W), .OCTET4_AT_LSB(OCTET4_AT_LSB)) u_dec (
      .hdr(in_hdr), .pti(pti), .is_oam(is_oam)
   );

   cell_steer_policy u_pol (
      .is_oam(is_oam), .known(in_known),
      .vc_oam_cpu(in_vc_oam_cpu), .vc_user_cpu(in_vc_user_cpu),
      .unk_user_cpu(cfg_unk_user_cpu), .unk_oam_cpu(cfg_unk_oam_cpu),
      .verdict(verdict)
   );

   cell_steer_outreg #(.TAG_W(TAG_W)) u_oreg (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready),
      .verdict(verdict), .pti(pti), .tag(in_tag),
      .drop_pulse(drop_pulse),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_dest(out_dest), .out_slot(out_slot),
      .out_pti(out_pti), .out_tag(out_tag)
   );

   cell_drop_counter #(.CNT_W(CNT_W), .SATURATE(CNT_SATURATE)) u_cnt (
      .clk(clk), .rst_n(rst_n), .bump(drop_pulse), .count(drop_count)
   );
endmodule

// File: rtl/cell_steer_chk.sv
module cell_steer_chk #(
   parameter int HDR_W         = 32,
   parameter bit OCTET4_AT_LSB = 1'b1,
   parameter int TAG_W         = 8,
   parameter int CNT_W         = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic [HDR_W-1:0] in_hdr,
   input logic [TAG_W-1:0] in_tag,
   input logic             in_known,
   input logic             in_vc_oam_cpu,
   input logic             in_vc_user_cpu,
   input logic             cfg_unk_user_cpu,
   input logic             cfg_unk_oam_cpu,
   input logic             out_valid,
   input logic             out_ready,
   input logic             out_dest,
   input logic [1:0]       out_slot,
   input logic [2:0]       out_pti,
   input logic [TAG_W-1:0] out_tag,
   input logic [CNT_W-1:0] drop_count
);
   logic [7:0] oct4;
   logic       acc, oam_in, drop_in;
   assign oct4    = OCTET4_AT_LSB ? in_hdr[7:0] : in_hdr[HDR_W-1 -: 8];
   assign oam_in  = oct4[3];
   assign acc     = in_valid && in_ready;
   assign drop_in = acc && !in_known && !(oam_in ? cfg_unk_oam_cpu : cfg_unk_user_cpu);

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> !out_valid && drop_count == '0);

   // R1
   pti_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc && in_known |=> out_pti == $past(oct4[3:1]) && out_tag == $past(in_tag));

   // R2 R3
   known_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc && in_known |=> out_valid && out_slot == 2'd0 &&
         out_dest == (out_pti[2] ? $past(in_vc_oam_cpu) : $past(in_vc_user_cpu)));

   // R4
   unk_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !in_known && !oam_in && cfg_unk_user_cpu |=>
         out_valid && out_dest && out_slot == 2'd1);

   // R5
   unk_oam_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !in_known && oam_in && cfg_unk_oam_cpu |=>
         out_valid && out_dest && out_slot == 2'd2);

   // R6
   drop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop_in |=> !out_valid);

   // R6
   cnt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !drop_in |=> $stable(drop_count));

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_dest) &&
         $stable(out_slot) && $stable(out_pti) && $stable(out_tag));

   // R8
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);
endmodule

bind cell_steer_top cell_steer_chk #(
   .HDR_W(HDR_W), .OCTET4_AT_LSB(OCTET4_AT_LSB), .TAG_W(TAG_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/cell_steer_top_tb.sv
module cell_steer_top_tb;
   localparam int CLK_PERIOD = 10;
   localparam int HDR_W = 32;
   localparam int TAG_W = 8;
   localparam int CNT_W = 4;
   localparam int CNT_MAX = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_known = 1'b0;
   logic in_vc_oam_cpu = 1'b0, in_vc_user_cpu = 1'b0;
   logic cfg_unk_user_cpu = 1'b0, cfg_unk_oam_cpu = 1'b0;
   logic out_ready = 1'b0;
   logic [HDR_W-1:0] in_hdr = '0;
   logic [TAG_W-1:0] in_tag = '0;
   logic in_ready, out_valid, out_dest;
   logic [1:0] out_slot;
   logic [2:0] out_pti;
   logic [TAG_W-1:0] out_tag;
   logic [CNT_W-1:0] drop_count;

   int total = 0, bad = 0;
   bit done = 0;

   // reference model state
   bit m_ov = 0, m_dest = 0;
   int m_slot = 0, m_pti = 0, m_tag = 0, m_cnt = 0;
   string m_req = "R9";
   int tag_seq = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cell_steer_top #(.HDR_W(HDR_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_hdr(in_hdr), .in_tag(in_tag), .in_known(in_known),
      .in_vc_oam_cpu(in_vc_oam_cpu), .in_vc_user_cpu(in_vc_user_cpu),
      .cfg_unk_user_cpu(cfg_unk_user_cpu), .cfg_unk_oam_cpu(cfg_unk_oam_cpu),
      .out_valid(out_valid), .out_ready(out_ready), .out_dest(out_dest),
      .out_slot(out_slot), .out_pti(out_pti), .out_tag(out_tag),
      .drop_count(drop_count)
   );

   task automatic check(bit ok, string req, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_step();
      bit acc, oam, flag;
      acc = in_valid && (!m_ov || out_ready);
      if (m_ov && out_ready) m_ov = 0;
      else if (m_ov) m_req = "R7";
      if (acc) begin
         oam = in_hdr[3];
         if (in_known) begin
            m_ov = 1; m_slot = 0;
            m_dest = oam ? in_vc_oam_cpu : in_vc_user_cpu;
            m_req = oam ? "R2" : "R3";
         end else begin
            flag = oam ? cfg_unk_oam_cpu : cfg_unk_user_cpu;
            if (flag) begin
               m_ov = 1; m_dest = 1; m_slot = oam ? 2 : 1;
               m_req = oam ? "R5" : "R4";
            end else begin
               m_req = "R6";
               if (m_cnt < CNT_MAX) m_cnt++;
            end
         end
         m_pti = int'(in_hdr[3:1]);
         m_tag = int'(in_tag);
      end
   endtask

   task automatic compare();
      check(out_valid == m_ov, m_req, "out_valid", int'(out_valid), int'(m_ov));
      check(in_ready == (!m_ov || out_ready), "R8", "in_ready",
            int'(in_ready), int'(!m_ov || out_ready));
      check(int'(drop_count) == m_cnt, "R6", "drop_count", int'(drop_count), m_cnt);
      if (m_ov && out_valid) begin
         check(out_dest == m_dest, m_req, "out_dest", int'(out_dest), int'(m_dest));
         check(int'(out_slot) == m_slot, m_req, "out_slot", int'(out_slot), m_slot);
         check(int'(out_pti) == m_pti, "R1", "out_pti", int'(out_pti), m_pti);
         check(int'(out_tag) == m_tag, "R7", "out_tag", int'(out_tag), m_tag);
      end
   endtask

   task automatic cycle();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
   endtask

   // present one cell: known, oam, per-VC flags, global flags, downstream ready
   task automatic send(bit k, bit oam, bit vo, bit vu, bit gu, bit go, bit rdy);
      logic [HDR_W-1:0] h;
      h = HDR_W'($urandom);
      h[3] = oam;
      in_valid = 1; in_known = k; in_hdr = h;
      in_vc_oam_cpu = vo; in_vc_user_cpu = vu;
      cfg_unk_user_cpu = gu; cfg_unk_oam_cpu = go;
      out_ready = rdy;
      in_tag = TAG_W'(tag_seq);
      tag_seq++;
      cycle();
   endtask

   task automatic idle(bit rdy);
      in_valid = 0; out_ready = rdy;
      cycle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check(out_valid == 1'b0, "R9", "out_valid in reset", int'(out_valid), 0);
      check(drop_count == '0, "R9", "drop_count in reset", int'(drop_count), 0);
      rst_n = 1;
      @(negedge clk);
      compare();
      // R2: known OAM, per-VC flag off then on, global flags set opposite
      send(1, 1, 0, 1, 1, 1, 1);
      send(1, 1, 1, 0, 0, 0, 1);
      // R3: known user cells
      send(1, 0, 1, 0, 1, 1, 1);
      send(1, 0, 0, 1, 0, 0, 1);
      // R4: unknown user, global on, per-VC flags off
      send(0, 0, 0, 0, 1, 0, 1);
      // R5: unknown OAM, global on
      send(0, 1, 0, 0, 0, 1, 1);
      // R6: unknown cells dropped despite per-VC flags set
      send(0, 0, 1, 1, 0, 1, 1);
      send(0, 1, 1, 1, 1, 0, 1);
      idle(1);
      // R7 / R8: backpressure holds a decision and stalls input
      send(1, 0, 0, 1, 0, 0, 0);
      send(0, 1, 0, 0, 0, 1, 0);
      send(0, 1, 0, 0, 0, 1, 0);
      idle(0);
      idle(1);
      idle(1);
      // R6 saturation of the drop counter
      for (int i = 0; i < 20; i++) send(0, i % 2, 1, 1, 0, 0, 1);
      idle(1);
      // mixed stream with random backpressure
      for (int i = 0; i < 400; i++) begin
         if ($urandom_range(0, 4) == 0) idle(1'($urandom));
         else send(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) != 0));
      end
      idle(1);
      idle(1);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule